// File: doc/BRIEF.md
# Inbound Doorbell Receiver and Responder

This block terminates doorbell requests arriving from the transport side of a serial interconnect endpoint. Each request carries a source identifier, a transaction tag and a 16-bit information word. The block stores the source and the information word in a receive queue and answers every request with a response record. The response has packet type 13 and reports either that the message was stored or that the sender must try again later.

A host reaches the block over a small word-addressed register bus. It pulls queued messages out of a data register, one per read, and reads the number of waiting messages from a count register. Two status bits share one interrupt line, each gated by its own enable bit. One bit flags stored doorbells. The other flags a valid response packet reported by the neighbouring logic. The doorbell bit clears itself when the queue drains, and software can also clear it by writing 1 to it.

The response leaves through a valid/ready record that holds one entry. While that record is held up, no new request is taken.

Top module: `db_rx_responder`

## Requirements
- R1: Every accepted request (`req_valid_i` and `req_ready_o` both high at a clock edge) produces exactly one response record. The record has `rsp_ftype_o` = 13, `rsp_dst_o` equal to the request source and `rsp_tid_o` equal to the request tag.
- R2: When the queue has space, the response status is DONE (4'b0000), and the source and information word are appended to the queue.
- R3: When the queue holds DEPTH entries, the response status is RETRY (4'b0011). The request is not stored, and the count and the queue contents are unchanged.
- R4: While `rsp_valid_o` is high and `rsp_ready_i` is low, the response fields hold steady and `req_ready_o` is low.
- R5: A read of address 0 returns {source, info}, with the source in bits [31:16] and the info word in bits [15:0], of the oldest entry. The read removes that entry, so the count is one lower from the next cycle. A read of address 0 while the queue is empty returns 0 and changes nothing.
- R6: Address 1 reads back the number of queued messages in its low bits.
- R7: Status bit 0 at address 2 is set by every stored doorbell.
- R8: Status bit 0 clears itself in the cycle after the queue becomes empty.
- R9: Writing 1 to bit 0 of address 2 clears status bit 0, and writing 0 to it has no effect. If a doorbell is stored in the same cycle, the bit stays set.
- R10: A pulse on `rsp_evt_i` sets status bit 1 at address 2, and writing 1 to that bit clears it.
- R11: Address 3 holds a 2-bit enable field, which can be written and read back. `irq_o` is high exactly when some status bit and its enable bit are both set.
- R12: When a doorbell is stored and an entry is removed in the same cycle, the count is unchanged and the messages keep their arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Doorbell request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_src_i | input | 16 | Request source identifier |
| req_tid_i | input | 8 | Request transaction tag |
| req_info_i | input | 16 | Doorbell information word |
| rsp_valid_o | output | 1 | Response record present |
| rsp_ready_i | input | 1 | Downstream accepts the response |
| rsp_ftype_o | output | 4 | Response packet type (13) |
| rsp_status_o | output | 4 | 0000 DONE, 0011 RETRY |
| rsp_dst_o | output | 16 | Response destination (request source) |
| rsp_tid_o | output | 8 | Echoed transaction tag |
| rsp_evt_i | input | 1 | A valid response packet was received elsewhere |
| reg_re_i | input | 1 | Register read strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Combined interrupt |

## Verification
Three pairs of events can fall in the same cycle. A stored doorbell can meet a host read that removes an entry. A stored doorbell can meet a write-1-to-clear of status bit 0. The read that empties the queue can also meet a new arrival. The bench starts the request driver and the register task at the same falling edge, so both events land on one rising edge. Afterwards it checks that the count did not move, that the message order matches the scoreboard model, and that status bit 0 is still set.

// File: rtl/db_rx_pkg.sv
package db_rx_pkg;
  localparam logic [3:0] FTYPE_RSP = 4'd13;

  typedef enum logic [3:0] {
    RSP_DONE  = 4'b0000,
    RSP_RETRY = 4'b0011
  } rsp_status_e;

  localparam int REG_DATA = 0;
  localparam int REG_CNT  = 1;
  localparam int REG_ISR  = 2;
  localparam int REG_IER  = 3;

  localparam int IRQ_N   = 2;
  localparam int IRQ_DB  = 0;
  localparam int IRQ_RSP = 1;
endpackage

// File: rtl/db_rx_fifo.sv
module db_rx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_pop_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));
  p_cnt_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && push_i) |=> $stable(cnt_o));
endmodule

// File: rtl/db_rsp_gen.sv
module db_rsp_gen
  import db_rx_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int TID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [SRC_W-1:0] req_src_i,
  input  logic [TID_W-1:0] req_tid_i,
  input  logic             fifo_full_i,
  output logic             store_o,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [3:0]       rsp_ftype_o,
  output logic [3:0]       rsp_status_o,
  output logic [SRC_W-1:0] rsp_dst_o,
  output logic [TID_W-1:0] rsp_tid_o
);
  logic             valid_q;
  rsp_status_e      status_q;
  logic [SRC_W-1:0] dst_q;
  logic [TID_W-1:0] tid_q;
  logic             accept;

  // single-entry response slot; a stalled slot blocks new requests
  assign req_ready_o = !valid_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;
  assign store_o     = accept && !fifo_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      status_q <= RSP_DONE;
      dst_q    <= '0;
      tid_q    <= '0;
    end else if (accept) begin
      valid_q  <= 1'b1;
      status_q <= fifo_full_i ? RSP_RETRY : RSP_DONE;
      dst_q    <= req_src_i;
      tid_q    <= req_tid_i;
    end else if (rsp_ready_i) begin
      valid_q  <= 1'b0;
    end
  end

  assign rsp_valid_o  = valid_q;
  assign rsp_ftype_o  = FTYPE_RSP;
  assign rsp_status_o = status_q;
  assign rsp_dst_o    = dst_q;
  assign rsp_tid_o    = tid_q;

  p_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !fifo_full_i) |=> (rsp_valid_o && rsp_status_o == RSP_DONE));
  p_retry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && fifo_full_i) |=> (rsp_valid_o && rsp_status_o == RSP_RETRY));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_status_o)
                                       && $stable(rsp_dst_o) && $stable(rsp_tid_o)));
  p_echo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (rsp_dst_o == $past(req_src_i) && rsp_tid_o == $past(req_tid_i)));
endmodule

// File: rtl/db_irq_ctrl.sv
module db_irq_ctrl
  import db_rx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rsp_evt_i,
  input  logic [IRQ_N-1:0] w1c_i,
  input  logic             en_we_i,
  input  logic [IRQ_N-1:0] en_wdata_i,
  output logic [IRQ_N-1:0] stat_o,
  output logic [IRQ_N-1:0] en_o,
  output logic             irq_o
);
  logic [IRQ_N-1:0] stat_q, en_q, set_vec, clr_vec;
  logic             drain;

  // queue is empty now or becomes empty at this edge
  assign drain = (cnt_i == '0) || (cnt_i == CNT_W'(1) && pop_i && !push_i);

  always_comb begin
    set_vec          = '0;
    set_vec[IRQ_DB]  = push_i;
    set_vec[IRQ_RSP] = rsp_evt_i;
    clr_vec          = w1c_i;
    clr_vec[IRQ_DB]  = w1c_i[IRQ_DB] || drain;
  end

  genvar g;
  generate
    for (g = 0; g < IRQ_N; g++) begin : g_stat
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           stat_q[g] <= 1'b0;
        else if (set_vec[g])   stat_q[g] <= 1'b1;
        else if (clr_vec[g])   stat_q[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = |(stat_q & en_q);

  p_db_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> stat_o[IRQ_DB]);
  p_selfclr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_i == CNT_W'(1)) |=> !stat_o[IRQ_DB]);
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_i[IRQ_DB] && !push_i) |=> !stat_o[IRQ_DB]);
  p_rsp_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_evt_i |=> stat_o[IRQ_RSP]);
endmodule

// File: rtl/db_rx_responder.sv
module db_rx_responder
  import db_rx_pkg::*;
#(
  parameter int SRC_W  = 16,
  parameter int INFO_W = 16,
  parameter int TID_W  = 8,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [SRC_W-1:0]  req_src_i,
  input  logic [TID_W-1:0]  req_tid_i,
  input  logic [INFO_W-1:0] req_info_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [3:0]        rsp_ftype_o,
  output logic [3:0]        rsp_status_o,
  output logic [SRC_W-1:0]  rsp_dst_o,
  output logic [TID_W-1:0]  rsp_tid_o,
  input  logic              rsp_evt_i,
  input  logic              reg_re_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int ENT_W = SRC_W + INFO_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             fifo_full, fifo_empty, store, pop;
  logic [ENT_W-1:0] fifo_rdata;
  logic [CNT_W-1:0] fifo_cnt;
  logic [IRQ_N-1:0] stat, en, w1c;
  logic             en_we;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:IRQ_N];

  db_rsp_gen #(.SRC_W(SRC_W), .TID_W(TID_W)) i_rsp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_src_i    (req_src_i),
    .req_tid_i    (req_tid_i),
    .fifo_full_i  (fifo_full),
    .store_o      (store),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_ready_i  (rsp_ready_i),
    .rsp_ftype_o  (rsp_ftype_o),
    .rsp_status_o (rsp_status_o),
    .rsp_dst_o    (rsp_dst_o),
    .rsp_tid_o    (rsp_tid_o)
  );

  assign pop = reg_re_i && (reg_addr_i == ADDR_W'(REG_DATA)) && !fifo_empty;

  db_rx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (store),
    .wdata_i ({req_src_i, req_info_i}),
    .pop_i   (pop),
    .rdata_o (fifo_rdata),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .cnt_o   (fifo_cnt)
  );

  assign w1c   = (reg_we_i && reg_addr_i == ADDR_W'(REG_ISR)) ? reg_wdata_i[IRQ_N-1:0] : '0;
  assign en_we = reg_we_i && (reg_addr_i == ADDR_W'(REG_IER));

  db_irq_ctrl #(.CNT_W(CNT_W)) i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (store),
    .pop_i      (pop),
    .cnt_i      (fifo_cnt),
    .rsp_evt_i  (rsp_evt_i),
    .w1c_i      (w1c),
    .en_we_i    (en_we),
    .en_wdata_i (reg_wdata_i[IRQ_N-1:0]),
    .stat_o     (stat),
    .en_o       (en),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_re_i) begin
      case (reg_addr_i)
        ADDR_W'(REG_DATA): if (!fifo_empty) reg_rdata_o = DATA_W'(fifo_rdata);
        ADDR_W'(REG_CNT):  reg_rdata_o = DATA_W'(fifo_cnt);
        ADDR_W'(REG_ISR):  reg_rdata_o = DATA_W'(stat);
        ADDR_W'(REG_IER):  reg_rdata_o = DATA_W'(en);
        default:           reg_rdata_o = '0;
      endcase
    end
  end

  p_irq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
  p_empty_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == ADDR_W'(REG_DATA) && fifo_cnt == '0) |-> (reg_rdata_o == '0));
endmodule

// File: tb/test_db_rx_responder.sv
`timescale 1ns/100ps
module test_db_rx_responder;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b1, rsp_evt = 1'b0;
  logic        reg_re = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [15:0] req_src = '0, req_info = '0;
  logic [7:0]  req_tid = '0;
  logic        req_ready, rsp_valid, irq;
  logic [3:0]  rsp_ftype, rsp_status;
  logic [15:0] rsp_dst;
  logic [7:0]  rsp_tid;
  logic [31:0] reg_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [27:0] exp_q[$];
  logic [31:0] mdl_q[$];

  always #2.5 clk = ~clk;

  db_rx_responder i_db_rx_responder (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_src_i(req_src), .req_tid_i(req_tid), .req_info_i(req_info),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_ftype_o(rsp_ftype), .rsp_status_o(rsp_status),
    .rsp_dst_o(rsp_dst), .rsp_tid_o(rsp_tid),
    .rsp_evt_i(rsp_evt),
    .reg_re_i(reg_re), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one request, expected response pushed to scoreboard
  task automatic send_db(input logic [15:0] src, input logic [7:0] tid, input logic [15:0] info);
    logic [3:0] st;
    @(negedge clk);
    req_valid = 1'b1; req_src = src; req_tid = tid; req_info = info;
    if (mdl_q.size() < DEPTH) begin st = 4'b0000; mdl_q.push_back({src, info}); end
    else st = 4'b0011;
    exp_q.push_back({src, tid, st});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_msg(input string req);
    logic [31:0] e, d;
    e = (mdl_q.size() != 0) ? mdl_q.pop_front() : 32'h0;
    reg_read(2'd0, d);
    chk(d == e, req, d, e);
  endtask

  // monitor: compare each response handshake against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected response", {16'h0, rsp_dst}, 32'h0);
        else begin
          logic [27:0] e;
          e = exp_q.pop_front();
          chk(rsp_ftype == 4'd13, "R1 ftype", 32'(rsp_ftype), 32'd13);
          chk({rsp_dst, rsp_tid} == e[27:4], "R1 dst/tid", 32'({rsp_dst, rsp_tid}), 32'(e[27:4]));
          chk(rsp_status == e[3:0], "R2/R3 status", 32'(rsp_status), 32'(e[3:0]));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rsp_valid == 1'b0 && irq == 1'b0 && req_ready == 1'b1, "reset", {29'h0, rsp_valid, irq, req_ready}, 32'h1);
    reg_read(2'd1, d); chk(d == 0, "R6 reset count", d, 0);
    reg_read(2'd0, d); chk(d == 0, "R5 empty read", d, 0);
    reg_read(2'd1, d); chk(d == 0, "R5 empty read no change", d, 0);

    // R2, R7, R6
    send_db(16'h1234, 8'h01, 16'hA001);
    reg_read(2'd2, d); chk(d[0] == 1'b1, "R7 set", d, 1);
    send_db(16'h0055, 8'h02, 16'hA002);
    send_db(16'h00AA, 8'h03, 16'hA003);
    reg_read(2'd1, d); chk(d == 3, "R6 count", d, 3);

    // R11 enable and irq
    chk(irq == 1'b0, "R11 irq masked", 32'(irq), 0);
    reg_write(2'd3, 32'h1);
    reg_read(2'd3, d); chk(d == 1, "R11 enable readback", d, 1);
    #1 chk(irq == 1'b1, "R11 irq on", 32'(irq), 1);

    // R9: write 0 no effect, write 1 clears while queue non-empty
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, d); chk(d[0] == 1'b1, "R9 write0 no effect", d, 1);
    reg_write(2'd2, 32'h1);
    reg_read(2'd2, d); chk(d[0] == 1'b0, "R9 w1c", d, 0);
    #1 chk(irq == 1'b0, "R11 irq off", 32'(irq), 0);

    // R9 same-cycle store wins over w1c
    fork
      send_db(16'h0777, 8'h04, 16'hA004);
      reg_write(2'd2, 32'h1);
    join
    reg_read(2'd2, d); chk(d[0] == 1'b1, "R9 store wins", d, 1);

    // R5 ordered reads and decrement
    read_msg("R5 read oldest");
    reg_read(2'd1, d); chk(d == 3, "R5 count dec", d, 3);

    // R12 push and pop in the same cycle
    begin
      logic [31:0] e;
      e = mdl_q[0];
      fork
        send_db(16'h0888, 8'h05, 16'hA005);
        reg_read(2'd0, d);
      join
      void'(mdl_q.pop_front());
      chk(d == e, "R12 pop data", d, e);
    end
    reg_read(2'd1, d); chk(d == 3, "R12 count unchanged", d, 3);

    // R3 fill then retry
    for (int i = 0; i < 6; i++) send_db(16'h0100 + 16'(i), 8'h10 + 8'(i), 16'hB000 + 16'(i));
    reg_read(2'd1, d); chk(d == DEPTH, "R3 full", d, DEPTH);
    send_db(16'h0BAD, 8'h20, 16'hDEAD);
    reg_read(2'd1, d); chk(d == DEPTH, "R3 count unchanged", d, DEPTH);

    // R4 backpressure
    @(negedge clk); rsp_ready = 1'b0;
    read_msg("R5 read before backpressure");
    send_db(16'h0C0C, 8'h30, 16'hC0C0);
    #1 chk(rsp_valid == 1'b1 && req_ready == 1'b0, "R4 stall", {30'h0, rsp_valid, req_ready}, 32'h2);
    repeat (3) @(negedge clk);
    #1 chk(rsp_dst == 16'h0C0C && req_ready == 1'b0, "R4 hold", 32'(rsp_dst), 32'h0C0C);
    @(negedge clk); rsp_ready = 1'b1;

    // R10 response event
    @(negedge clk); rsp_evt = 1'b1;
    @(negedge clk); rsp_evt = 1'b0;
    reg_read(2'd2, d); chk(d[1] == 1'b1, "R10 set", d, 2);
    #1 chk(irq == 1'b1, "R11 irq db", 32'(irq), 1);
    reg_write(2'd3, 32'h2);
    reg_write(2'd2, 32'h2);
    reg_read(2'd2, d); chk(d[1] == 1'b0, "R10 w1c", d, 0);
    #1 chk(irq == 1'b0, "R11 irq after rsp clear", 32'(irq), 0);

    // R8 drain clears bit0
    while (mdl_q.size() > 0) read_msg("R5 drain order");
    reg_read(2'd2, d); chk(d[0] == 1'b0, "R8 self clear", d, 0);
    reg_read(2'd0, d); chk(d == 0, "R5 empty after drain", d, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all responses seen", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule